// File: doc/BRIEF.md
# Memory-Window I2C Target with Address-Carrying Control Byte

This block is a byte-oriented I2C target that fronts a 2048-byte memory space. It oversamples SCL and SDA with the system clock, cleans both lines through a synchronizer and a persistence filter, and recognises START, repeated START and STOP. The first byte after a START is a control byte whose upper nibble is a fixed 1010 prefix. Its next three bits are the top three bits of the memory address, and its last bit selects the direction. For a write, a second byte supplies the low eight address bits and every following byte is stored. For a read, the master sets the address with a write-direction header, issues a repeated START, and then clocks out bytes from an auto-incrementing pointer.

The back end sees a plain memory port. A one-cycle write strobe carries address and data. A one-cycle read request carries an address, and the returned byte is expected on the cycle after the request. SDA is driven only as an open-drain pull-down enable. An active-low protect input is captured at each START and, when low, makes the target refuse every data byte of that write.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset the SDA pull-down is off and no strobe is active. Bytes clocked on the bus before any START are never acknowledged.
- R2: A control byte is acknowledged only when its upper nibble is 1010. Any other prefix gets no acknowledge, and the target ignores the bus until the next START.
- R3: Control-byte bits 3..1 become address bits 10..8 and the following address byte becomes bits 7..0. Both bytes are acknowledged.
- R4: Each write data byte is acknowledged and produces one write strobe with the current pointer and the byte. The pointer then advances by one and wraps from 0x7FF to 0x000.
- R5: The protect input is sampled at START. When it was low, write data bytes are not acknowledged and no strobe is issued. The target then stays silent until the next START, even if the input rises mid-transaction.
- R6: Control byte (bit 0 = 0), address byte, repeated START, then control byte with bit 0 = 1 returns the byte at the set address, most significant bit first. A read request for that address is issued before the first bit is driven.
- R7: While the master acknowledges, further bytes follow from the pointer plus one, wrapping from 0x7FF to 0x000. After a master non-acknowledge, SDA stays released and no further bytes or read requests occur until the next START.
- R8: The SDA pull-down changes only while SCL is low.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R10: After a STOP the target is idle, and a byte sent without a new START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| wp_n | input | 1 | Write protect, active low, sampled at START |
| mem_addr | output | ADDR_W (11) | Memory address for strobe or request |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |

## Verification
On every cycle, the embedded properties check several rules. The pull-down only changes after a low SCL. A START always leaves the engine at the start of a control byte with SDA released. Strobes occur only while acknowledging and never under protection. Each strobe is followed by a pointer step of one, modulo the space. Filtered lines only take a value the synchronizer has shown. Whether bytes carry the right address and data, how prefixes are accepted, how sequential reads wrap, and how glitches are rejected can only be shown by the bench's bus scenarios. The bench sweeps all sixteen prefixes and all eight high-address values and compares each result with arithmetic expectations.

// File: rtl/i2c_addr_slave_pkg.sv
package i2c_addr_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WR,
    ST_SACK,
    ST_RD,
    ST_WAIT
  } slv_state_t;

  localparam logic [3:0] CTRL_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          filt_q, filt_n;

  always_comb begin
    cnt_n  = cnt_q;
    filt_n = filt_q;
    if (sync_q[1] == filt_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      filt_n = sync_q[1];
      cnt_n  = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      cnt_q  <= cnt_n;
      filt_q <= filt_n;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(sync_q[1]))); // R9

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign ev_rise  = scl_f & ~scl_q;
  assign ev_fall  = ~scl_f & scl_q;
  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_addr_slave_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              wp_n,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_rd_req,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - 8;

  slv_state_t        state, state_n, ret_st, ret_n;
  logic [3:0]        bit_cnt, cnt_n;
  logic [7:0]        shreg, sh_n, tx, tx_n, wdata_q, wd_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic              oe_q, oe_n, wp_lat, wpl_n;
  logic              we_q, we_n, fetch_q, fetch_n, cap_q, cap_n;

  always_comb begin
    state_n = state;
    ret_n   = ret_st;
    cnt_n   = bit_cnt;
    sh_n    = shreg;
    tx_n    = tx;
    oe_n    = oe_q;
    ptr_n   = ptr;
    wpl_n   = wp_lat;
    wd_n    = wdata_q;
    we_n    = 1'b0;
    fetch_n = 1'b0;
    cap_n   = fetch_q;
    if (cap_q) tx_n = mem_rdata;
    if (we_q)  ptr_n = ptr + 1'b1;

    if (ev_stop) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      cnt_n   = '0;
    end else if (ev_start) begin
      state_n = ST_CTRL;
      oe_n    = 1'b0;
      cnt_n   = '0;
      wpl_n   = wp_n;
    end else begin
      unique case (state)
        ST_CTRL, ST_ADDR, ST_WR: begin
          if (ev_rise && bit_cnt < 4'd8) begin
            sh_n  = {shreg[6:0], sda_f};
            cnt_n = bit_cnt + 1'b1;
          end else if (ev_fall && bit_cnt == 4'd8) begin
            state_n = ST_WAIT;
            if (state == ST_CTRL) begin
              if (shreg[7:4] == CTRL_PREFIX) begin
                state_n                = ST_SACK;
                oe_n                   = 1'b1;
                ptr_n[ADDR_W-1:8]      = shreg[HI_W:1];
                ret_n                  = shreg[0] ? ST_RD : ST_ADDR;
                fetch_n                = shreg[0];
              end
            end else if (state == ST_ADDR) begin
              state_n    = ST_SACK;
              oe_n       = 1'b1;
              ptr_n[7:0] = shreg;
              ret_n      = ST_WR;
            end else if (wp_lat) begin
              state_n = ST_SACK;
              oe_n    = 1'b1;
              we_n    = 1'b1;
              wd_n    = shreg;
              ret_n   = ST_WR;
            end
          end
        end
        ST_SACK: begin
          if (ev_rise) begin
            cnt_n = 4'd9;
          end else if (ev_fall && bit_cnt == 4'd9) begin
            cnt_n   = '0;
            state_n = ret_st;
            oe_n    = (ret_st == ST_RD) ? ~tx[7] : 1'b0;
          end
        end
        ST_RD: begin
          if (ev_rise) begin
            if (bit_cnt < 4'd8) begin
              cnt_n = bit_cnt + 1'b1;
            end else if (bit_cnt == 4'd8) begin
              ptr_n = ptr + 1'b1;
              if (!sda_f) begin
                fetch_n = 1'b1;
                cnt_n   = 4'd9;
              end else begin
                state_n = ST_WAIT;
              end
            end
          end else if (ev_fall) begin
            if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
              tx_n = {tx[6:0], 1'b0};
              oe_n = ~tx[6];
            end else if (bit_cnt == 4'd8) begin
              oe_n = 1'b0;
            end else if (bit_cnt == 4'd9) begin
              cnt_n = '0;
              oe_n  = ~tx[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ret_st  <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      tx      <= '0;
      oe_q    <= 1'b0;
      ptr     <= '0;
      wp_lat  <= 1'b1;
      wdata_q <= '0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      state   <= state_n;
      ret_st  <= ret_n;
      bit_cnt <= cnt_n;
      shreg   <= sh_n;
      tx      <= tx_n;
      oe_q    <= oe_n;
      ptr     <= ptr_n;
      wp_lat  <= wpl_n;
      wdata_q <= wd_n;
      we_q    <= we_n;
      fetch_q <= fetch_n;
      cap_q   <= cap_n;
    end
  end

  assign sda_oe     = oe_q;
  assign mem_addr   = ptr;
  assign mem_wdata  = wdata_q;
  assign mem_we     = we_q;
  assign mem_rd_req = fetch_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !$past(scl_f)); // R8

  AST_START_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_stop) |=> (state == ST_CTRL) && (bit_cnt == 4'd0) && !oe_q); // R1

  AST_WE_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (state == ST_SACK) && oe_q); // R4

  AST_WE_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R4

  AST_NO_WE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_lat |-> !we_q); // R5

  AST_RDREQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |-> (state == ST_SACK) || (state == ST_RD)); // R6

  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !oe_q); // R7

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter int FILT_LEN = 4,
  parameter int ADDR_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wp_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_rd_req,
  input  logic [7:0]        mem_rdata
);
  localparam int NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [NLINES-1:0] line_raw, line_f;
  logic              ev_rise, ev_fall, ev_start, ev_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .raw_i  (line_raw[g]),
      .filt_o (line_f[g])
    );
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_f    (line_f[1]),
    .sda_f    (line_f[0]),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  i2c_proto_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_f      (line_f[1]),
    .sda_f      (line_f[0]),
    .ev_rise    (ev_rise),
    .ev_fall    (ev_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .wp_n       (wp_n),
    .sda_oe     (sda_oe),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_rd_req (mem_rd_req),
    .mem_rdata  (mem_rdata)
  );

endmodule

// File: tb/i2c_addr_slave_tb.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;
  localparam int FILT       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1, wp_n = 1'b1;
  logic        sda_oe, mem_we, mem_rd_req;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  wire         sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0, rd_cnt = 0, oe_viol = 0;
  logic [10:0] last_wa = '0, last_ra = '0;
  logic [7:0]  last_wd = '0;
  logic        oe_prev = 1'b0;
  logic [7:0]  mem [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_slave #(.FILT_LEN(FILT), .ADDR_W(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wp_n(wp_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rd_req(mem_rd_req), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) + 3);
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt  <= we_cnt + 1;
      last_wa <= mem_addr;
      last_wd <= mem_wdata;
    end
    if (mem_rd_req) begin
      mem_rdata <= mem[mem_addr];
      rd_cnt    <= rd_cnt + 1;
      last_ra   <= mem_addr;
    end
    oe_prev <= sda_oe;
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol <= oe_viol + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  // entered with SCL low; returns 1 when the target acknowledged
  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // same as send_byte but with short glitches on both lines
  task automatic send_glitchy(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      if (i == 4) begin
        scl_m = 1'b1; tick(FILT - 2);
        scl_m = 1'b0; tick(Q);
      end
      scl_m = 1'b1; tick(Q);
      if (b[i]) begin
        sda_m = 1'b0; tick(FILT - 2);
        sda_m = 1'b1;
      end
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0;
    end
    tick(1);
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(1);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic set_addr(input logic [10:0] a);
    bit ack;
    bus_start();
    send_byte({4'hA, a[10:8], 1'b0}, ack);
    chk(ack, "R3 ctrl ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R3 addr ack", ack, 1);
  endtask

  bit done = 1'b0;

  initial begin
    bit ack;
    logic [7:0] rb;
    int wc, rc;
    for (int a = 0; a < 2048; a++) mem[a] = pat(a);
    mem_rdata = '0;
    tick(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(mem_we == 1'b0 && mem_rd_req == 1'b0, "R1 reset strobes", {mem_we, mem_rd_req}, 0);
    rst_n = 1'b1;
    tick(10);

    // R1 no START: byte ignored
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA0, ack);
    chk(!ack, "R1 byte before START", ack, 0);
    bus_stop();

    // R2 sweep of all sixteen prefixes
    for (int n = 0; n < 16; n++) begin
      bus_start();
      send_byte({4'(n), 4'b0000}, ack);
      chk(ack == (n == 10), "R2 prefix ack", ack, (n == 10));
      bus_stop();
    end

    // R3 R4 sweep of high address bits, single-byte writes
    for (int h = 0; h < 8; h++) begin
      wc = we_cnt;
      set_addr({3'(h), 8'h5C});
      send_byte(8'(h * 17 + 1), ack);
      chk(ack, "R4 data ack", ack, 1);
      bus_stop();
      chk(we_cnt == wc + 1, "R4 one strobe", we_cnt - wc, 1);
      chk(last_wa == {3'(h), 8'h5C}, "R3 write address", last_wa, {3'(h), 8'h5C});
      chk(last_wd == 8'(h * 17 + 1), "R4 write data", last_wd, 8'(h * 17 + 1));
    end

    // R4 multi-byte write with wrap 0x7FE,0x7FF,0x000
    set_addr(11'h7FE);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'h11 * (k + 1)), ack);
      chk(ack, "R4 burst ack", ack, 1);
      chk(last_wa == 11'(11'h7FE + k), "R4 burst addr wrap", last_wa, 11'(11'h7FE + k));
    end
    bus_stop();

    // R5 write protect latched at START
    wc = we_cnt;
    wp_n = 1'b0;
    set_addr(11'h3A0);
    send_byte(8'hC3, ack);
    chk(!ack, "R5 protected data nack", ack, 0);
    wp_n = 1'b1;
    send_byte(8'hC4, ack);
    chk(!ack, "R5 still silent after wp rise", ack, 0);
    bus_stop();
    chk(we_cnt == wc, "R5 no strobe", we_cnt - wc, 0);

    // R6 random read, including the protected location
    set_addr(11'h3A0);
    bus_start();
    send_byte({4'hA, 3'h3, 1'b1}, ack);
    chk(ack, "R6 read ctrl ack", ack, 1);
    recv_byte(1'b0, rb);
    bus_stop();
    chk(rb == pat(11'h3A0), "R5 R6 protected byte unchanged", rb, pat(11'h3A0));
    chk(last_ra == 11'h3A0, "R6 read request addr", last_ra, 11'h3A0);

    set_addr(11'h234);
    bus_start();
    send_byte({4'hA, 3'h2, 1'b1}, ack);
    recv_byte(1'b0, rb);
    bus_stop();
    chk(rb == pat(11'h234), "R6 random read data", rb, pat(11'h234));

    // R7 sequential read across the top of the space
    set_addr(11'h7FD);
    bus_start();
    send_byte({4'hA, 3'h7, 1'b1}, ack);
    chk(ack, "R7 read ctrl ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      case (k)
        0: e = pat(11'h7FD);
        1: e = 8'h11;
        2: e = 8'h22;
        default: e = 8'h33;
      endcase
      recv_byte(k < 3, rb);
      chk(rb == e, "R7 sequential data", rb, e);
    end
    rc = rd_cnt;
    recv_byte(1'b0, rb);
    chk(rb == 8'hFF, "R7 released after nack", rb, 8'hFF);
    chk(rd_cnt == rc, "R7 no request after nack", rd_cnt - rc, 0);
    bus_stop();

    // R10 idle after STOP
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA0, ack);
    chk(!ack, "R10 byte after STOP", ack, 0);
    bus_stop();

    // R9 glitches on both lines during a data byte
    set_addr(11'h110);
    send_glitchy(8'h5A, ack);
    chk(ack, "R9 glitchy byte ack", ack, 1);
    bus_stop();
    chk(last_wa == 11'h110 && last_wd == 8'h5A, "R9 glitchy byte data", last_wd, 8'h5A);

    // R8 pull-down never toggled with SCL high
    chk(oe_viol == 0, "R8 sda_oe change with SCL high", oe_viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule